// File: doc/BRIEF.md
# SPI FIFO Interrupt Threshold Generator

This block produces the transmit and receive interrupt flags of an SPI controller. A 3-bit threshold code sets how many bytes must go out on the wire before the transmit flag is raised, and how many bytes must wait in the receive FIFO before the receive flag is raised. A one-cycle strobe marks each byte that finishes on the wire. A 4-bit occupancy input reports how full the 8-entry receive FIFO is.

For a threshold code c from 0 to 6 the limit is c+1 bytes. The top code (7) uses 8 bytes for transmit and full occupancy for receive. When receive data is moved by DMA, the block uses code 0 regardless of the programmed code, so every received byte raises a request. The transmit flag is sticky and stays set until software clears it. The receive flag follows the occupancy level.

Top module: `spi_irq_thresh`

## Requirements
- R1: After reset both flags are 0, the transmit byte count is 0 and the registered effective code is 0.
- R2: For an effective code c in 0..6, tx_irq_o becomes 1 at the clock edge that samples the (c+1)-th byte_done_i pulse counted since the count last restarted. The count then restarts from 0.
- R3: For effective code 7, tx_irq_o becomes 1 at the edge that samples the 8th counted byte.
- R4: For an effective code c in 0..6, rx_irq_o after an edge equals (rx_level_i >= c+1) as sampled at that edge.
- R5: For effective code 7, rx_irq_o after an edge is 1 only if rx_level_i == 8 was sampled at that edge.
- R6: While dma_rx_i is 1, the effective code is 0 for both flags, whatever mode_i holds.
- R7: Once set, tx_irq_o stays 1 until an edge samples irq_clr_i = 1.
- R8: An edge that samples irq_clr_i = 1 clears tx_irq_o and resets the count to 0. A byte_done_i pulse sampled at the same edge counts as the first byte of the new count. If that byte reaches the threshold, the flag is set and the set wins over the clear.
- R9: rx_irq_o drops on the edge after the occupancy is sampled below the threshold.
- R10: If the effective code sampled at an edge differs from the registered one, the count restarts from 0 and any byte sampled at that edge is dropped. Later bytes are compared against the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Threshold code |
| dma_rx_i | input | 1 | Receive serviced by DMA; forces code 0 |
| byte_done_i | input | 1 | One pulse per byte completed on the wire |
| rx_level_i | input | 4 | Receive FIFO occupancy, 0..8 |
| irq_clr_i | input | 1 | Clears the transmit flag and the count |
| tx_irq_o | output | 1 | Sticky transmit interrupt |
| rx_irq_o | output | 1 | Level receive interrupt |

## Verification
The case hardest to reach from the ports is a clear, a byte strobe and sometimes a code change all landing on the same edge, while the count sits one short of the threshold. Directed sequences count bytes up to exactly that point and then apply each combination. A long random phase follows, with frequent strobes and clears, occasional code and DMA toggles, and a behavioural model checked on every clock. Occupancy 8 under code 7, and occupancy 7 just below it, are driven on purpose to separate the full-only condition from the general rule.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    // Byte threshold selected by a code: one more than the code value.
    function automatic int unsigned code_limit(input int unsigned code);
        return code + 1;
    endfunction
endpackage

// File: rtl/spi_irq_mode.sv
module spi_irq_mode #(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              dma_rx_i,
    output logic [MODE_W-1:0] eff_now_o,
    output logic [MODE_W-1:0] eff_reg_o,
    output logic              changed_o
);
    typedef struct packed {
        logic [MODE_W-1:0] eff;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic [MODE_W-1:0] eff_now;

    always_comb begin
        eff_now = dma_rx_i ? '0 : mode_i;
        st_d    = st_q;
        st_d.eff = eff_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eff_now_o = eff_now;
    assign eff_reg_o = st_q.eff;
    assign changed_o = (eff_now != st_q.eff);
endmodule

// File: rtl/spi_irq_txcnt.sv
module spi_irq_txcnt #(
    parameter int MODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] eff_i,
    input  logic              changed_i,
    input  logic              byte_i,
    input  logic              clr_i,
    output logic              irq_o
);
    import spi_irq_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic [CNT_W-1:0] base, next_cnt, limit;

    always_comb begin
        st_d     = st_q;
        limit    = CNT_W'(code_limit(int'(eff_i)));
        base     = clr_i ? '0 : st_q.cnt;
        next_cnt = base + CNT_W'(1);
        if (clr_i) st_d.irq = 1'b0;
        if (changed_i) begin
            st_d.cnt = '0;
        end else if (byte_i) begin
            if (next_cnt >= limit) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = next_cnt;
            end
        end else begin
            st_d.cnt = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/spi_irq_rxcmp.sv
module spi_irq_rxcmp #(
    parameter int MODE_W = 3,
    parameter int DEPTH  = 8,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] eff_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic              irq_o
);
    import spi_irq_pkg::*;

    localparam logic [MODE_W-1:0] TOP_CODE = '1;

    typedef struct packed {
        logic irq;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [LVL_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = LVL_W'(code_limit(int'(eff_i)));
        if (eff_i == TOP_CODE) st_d.irq = (level_i == LVL_W'(DEPTH));
        else                   st_d.irq = (level_i >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/spi_irq_thresh.sv
module spi_irq_thresh #(
    parameter int MODE_W = 3,
    parameter int DEPTH  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              dma_rx_i,
    input  logic              byte_done_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic              irq_clr_i,
    output logic              tx_irq_o,
    output logic              rx_irq_o
);
    logic [MODE_W-1:0] eff_now, eff_reg;
    logic              changed;

    spi_irq_mode #(.MODE_W(MODE_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dma_rx_i(dma_rx_i),
        .eff_now_o(eff_now), .eff_reg_o(eff_reg), .changed_o(changed)
    );

    spi_irq_txcnt #(.MODE_W(MODE_W), .CNT_W(LVL_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .eff_i(eff_reg), .changed_i(changed),
        .byte_i(byte_done_i), .clr_i(irq_clr_i), .irq_o(tx_irq_o)
    );

    spi_irq_rxcmp #(.MODE_W(MODE_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .eff_i(eff_now), .level_i(rx_level_i),
        .irq_o(rx_irq_o)
    );
endmodule

// File: rtl/spi_irq_thresh_chk.sv
module spi_irq_thresh_chk #(
    parameter int MODE_W = 3,
    parameter int LVL_W  = 4,
    parameter int DEPTH  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic              dma_rx_i,
    input logic              byte_done_i,
    input logic [LVL_W-1:0]  rx_level_i,
    input logic              irq_clr_i,
    input logic              tx_irq_o,
    input logic              rx_irq_o
);
    // R7
    tx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq_o && !irq_clr_i |=> tx_irq_o);
    // R1
    tx_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_irq_o && !byte_done_i |=> !tx_irq_o);
    // R8
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_i && !byte_done_i |=> !tx_irq_o);
    // R5
    rx_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_rx_i && mode_i == '1 && rx_level_i != LVL_W'(DEPTH) |=> !rx_irq_o);
    // R6
    rx_dma_each_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_i && rx_level_i != '0 |=> rx_irq_o);
    // R9
    rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level_i == '0 |=> !rx_irq_o);
endmodule

bind spi_irq_thresh spi_irq_thresh_chk #(.MODE_W(MODE_W), .LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dma_rx_i(dma_rx_i),
    .byte_done_i(byte_done_i), .rx_level_i(rx_level_i), .irq_clr_i(irq_clr_i),
    .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
);

// File: tb/spi_irq_thresh_test.sv
module spi_irq_thresh_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = '0;
    logic       dma = 1'b0;
    logic       bdone = 1'b0;
    logic [3:0] lvl = '0;
    logic       clr = 1'b0;
    logic       tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_eff = 0;
    int m_cnt = 0;
    bit m_tx = 0;
    bit m_rx = 0;

    always #10 clk = ~clk; // 50 MHz

    spi_irq_thresh uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dma_rx_i(dma),
        .byte_done_i(bdone), .rx_level_i(lvl), .irq_clr_i(clr),
        .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
    );

    // Behavioural model of the requirements, advanced at each active edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_eff = 0; m_cnt = 0; m_tx = 0; m_rx = 0;
        end else begin
            int now_eff;
            int lim;
            now_eff = dma ? 0 : int'(mode);            // R6
            m_rx = (now_eff == 7) ? (lvl == 8) : (int'(lvl) >= now_eff + 1); // R4 R5 R9
            lim = m_eff + 1;                             // R2 R3
            if (clr) begin m_tx = 0; m_cnt = 0; end      // R8
            if (now_eff != m_eff) m_cnt = 0;             // R10
            else if (bdone) begin
                m_cnt++;
                if (m_cnt >= lim) begin m_cnt = 0; m_tx = 1; end
            end
            m_eff = now_eff;
        end
    end

    task automatic check(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R3/R7/R8/R10 tx", tx_irq, m_tx);
            check("R4/R5/R6/R9 rx", rx_irq, m_rx);
        end
    end

    task automatic step(input bit b, input bit c);
        bdone = b; clr = c;
        @(negedge clk);
        bdone = 0; clr = 0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 tx reset", tx_irq, 1'b0);
        check("R1 rx reset", rx_irq, 1'b0);
        rst_n = 1;
        @(negedge clk);

        // R2: code 2 -> fires on third byte
        mode = 3'd2; @(negedge clk);
        step(1, 0); step(1, 0);
        check("R2 before threshold", tx_irq, 1'b0);
        step(1, 0);
        check("R2 at threshold", tx_irq, 1'b1);
        // R7: sticky
        step(0, 0); step(1, 0);
        check("R7 sticky", tx_irq, 1'b1);
        // R8: clear with byte at code 2 -> cleared, count=1
        step(1, 1);
        check("R8 clear", tx_irq, 1'b0);
        step(1, 0);
        check("R8 byte counted on clear", tx_irq, 1'b0);
        step(1, 0);
        check("R8 third byte after clear", tx_irq, 1'b1);
        // R8: set wins over clear at code 0
        mode = 3'd0; @(negedge clk); step(0, 1);
        step(1, 1);
        check("R8 set wins", tx_irq, 1'b1);
        step(0, 1);
        // R3: code 7 needs 8 bytes
        mode = 3'd7; @(negedge clk);
        for (int i = 0; i < 7; i++) step(1, 0);
        check("R3 seven bytes", tx_irq, 1'b0);
        step(1, 0);
        check("R3 eighth byte", tx_irq, 1'b1);
        step(0, 1);
        // R10: change code with byte on that edge -> byte dropped
        mode = 3'd1; step(1, 0);
        step(1, 0);
        check("R10 dropped byte", tx_irq, 1'b0);
        step(1, 0);
        check("R10 new threshold", tx_irq, 1'b1);
        step(0, 1);
        // R5: code 7 rx only when full
        mode = 3'd7; lvl = 4'd7; @(negedge clk);
        check("R5 seven not full", rx_irq, 1'b0);
        lvl = 4'd8; @(negedge clk);
        check("R5 full", rx_irq, 1'b1);
        // R4 / R9
        mode = 3'd3; lvl = 4'd4; @(negedge clk);
        check("R4 at threshold", rx_irq, 1'b1);
        lvl = 4'd3; @(negedge clk);
        check("R9 below threshold", rx_irq, 1'b0);
        // R6: DMA forces code 0
        dma = 1; lvl = 4'd1; @(negedge clk);
        check("R6 dma rx one byte", rx_irq, 1'b1);
        step(0, 0); step(1, 0);
        check("R6 dma tx one byte", tx_irq, 1'b1);
        dma = 0; step(0, 1);

        // Random phase, model compared every clock
        for (int i = 0; i < 4000; i++) begin
            bdone = ($urandom % 3) != 0;
            clr   = ($urandom % 7) == 0;
            if (($urandom % 40) == 0) mode = 3'($urandom);
            if (($urandom % 60) == 0) dma = ~dma;
            lvl = 4'($urandom % 9);
            @(negedge clk);
        end
        bdone = 0; clr = 0;
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule